// File: doc/BRIEF.md
# Dual-Set Endpoint Packet FIFO

This block is the byte store behind one endpoint of a USB function. It keeps up to two whole packets, each of any length that fits, in a single circular byte array. A producer writes bytes one per cycle and closes them off as a packet with a commit. A consumer reads bytes from the oldest closed packet and drops that packet with a release, which makes the next packet current. Each closed packet keeps its own byte count, so the consumer knows how many bytes to take.

Two rewind commands support protocol retries. A retransmit rewind returns the read side to the first byte of the current packet so the packet can go out again. A re-receive rewind throws away the packet the producer is still writing, so the same packet can be taken in again. A flush clears all state in one cycle. The block raises a one-cycle pulse for every accepted commit and every release, which can drive an endpoint interrupt. It also keeps sticky flags for writes that were lost, reads that found no data, and commits that were refused.

The default depth is 16 bytes, which suits a control endpoint. The depth is a parameter, so a large data endpoint can use up to 1024 bytes. The reset input is asynchronous and active low. Its release is assumed to be synchronised to `clk` upstream.

Top module: `ep_dualset_fifo`

## Requirements
- R1: Bytes come out in the order they went in, including when the read and write positions wrap from DEPTH-1 back to 0.
- R2: At most two committed packets are held at once (`sets_held` is 0, 1 or 2). A commit made while two are already held is refused and sets `commit_err`, which stays set until reset or flush.
- R3: `cur_count` gives the byte count of the oldest committed packet and `next_count` gives the count of the second one. Each count is 0 when that packet is not present.
- R4: `full` is 1 exactly when `free_count` is 0, and `empty` is 1 exactly when no committed packet is held. Both outputs reflect the state after the clock edge of the operation that changed them. After reset, `empty`=1, `full`=0 and `free_count`=DEPTH.
- R5: `rd_rewind` moves the read side back to the first byte of the current packet, so the next read returns that byte again. It takes priority over `rd_release` and `rd_en` in the same cycle, and those two are ignored.
- R6: `wr_rewind` discards every byte of the uncommitted packet, and the space returns to `free_count`. It takes priority over `wr_en` and `wr_commit` in the same cycle, and those two are ignored without setting any flag.
- R7: `rd_release` with at least one packet held drops the current packet. On the same edge the second packet's count moves into `cur_count`, and `tx_done` is 1 for the following cycle. A release with no packet held does nothing.
- R8: An accepted commit closes the uncommitted bytes as a new packet, including a byte written in the same cycle, and `rx_done` is 1 for the following cycle. A commit with no uncommitted bytes creates a packet of length 0.
- R9: A write while `full` is ignored and sets the sticky `overflow` flag. A read when the current packet has no unread byte, or when no packet is held, leaves `rd_data` unchanged and sets the sticky `underflow` flag.
- R10: `flush` has priority over every other input. In one cycle it empties both packets, the uncommitted bytes, both positions and all three sticky flags, and it leaves `rd_data` unchanged.
- R11: `free_count` equals DEPTH minus the bytes of the committed packets minus the uncommitted bytes. Reads do not change it until the packet is released.
- R12: `rd_data` presents the byte taken by an accepted `rd_en`, starting from the clock edge that accepts the read. The value holds until the next accepted read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Clear all packets, positions and sticky flags |
| wr_en | input | 1 | Write `wr_data` into the uncommitted packet |
| wr_data | input | DW | Byte to write |
| wr_commit | input | 1 | Close the uncommitted bytes as a packet |
| wr_rewind | input | 1 | Discard the uncommitted packet (re-receive) |
| rd_en | input | 1 | Read the next byte of the current packet |
| rd_release | input | 1 | Drop the current packet |
| rd_rewind | input | 1 | Restart reading the current packet (retransmit) |
| rd_data | output | DW | Last byte read |
| full | output | 1 | No free byte remains |
| empty | output | 1 | No committed packet is held |
| free_count | output | $clog2(DEPTH+1) | Free bytes |
| cur_count | output | $clog2(DEPTH+1) | Byte count of the current packet |
| next_count | output | $clog2(DEPTH+1) | Byte count of the second packet |
| sets_held | output | 2 | Number of committed packets |
| overflow | output | 1 | Sticky: a write was lost |
| underflow | output | 1 | Sticky: a read found no byte |
| commit_err | output | 1 | Sticky: a commit was refused |
| tx_done | output | 1 | One-cycle pulse after a release |
| rx_done | output | 1 | One-cycle pulse after an accepted commit |

## Verification
The assertions allow any combination of command inputs in a cycle, because the block defines a priority for every combination. They do assume that `rst_n` rises away from the clock edge and that the inputs are stable around each rising edge. The bench changes every input on the falling edge, so both assumptions hold. It also sets each command bit independently at random, which produces concurrent commit with release, rewind with read, and flush with everything else without any extra constraint.

// File: rtl/ep_dualset_fifo_pkg.sv
package ep_dualset_fifo_pkg;

  typedef enum logic [1:0] {
    SETS_NONE = 2'd0,
    SETS_ONE  = 2'd1,
    SETS_TWO  = 2'd2
  } sets_e;

endpackage

// File: rtl/epf_store.sv
module epf_store #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rdata_q;
  logic [DW-1:0] rdata_d;

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  always_comb begin
    rdata_d = rdata_q;
    if (re) begin
      rdata_d = mem[raddr];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (re) begin
      rdata_q <= rdata_d;
    end
  end

  assign rdata = rdata_q;

endmodule

// File: rtl/epf_write_ctrl.sv
module epf_write_ctrl #(
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH),
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          wr_en,
  input  logic          wr_commit,
  input  logic          wr_rewind,
  input  logic          full,
  input  logic          queue_full,
  output logic [AW-1:0] wptr,
  output logic          mem_we,
  output logic [CW-1:0] part_cnt,
  output logic          commit_ok,
  output logic [CW-1:0] commit_cnt,
  output logic          ovf_set,
  output logic          cerr_set
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0] wptr_q, wptr_d;
  logic [AW-1:0] wstart_q, wstart_d;
  logic [CW-1:0] part_q, part_d;
  logic [CW-1:0] part_inc;
  logic          wr_ok;
  logic          active;

  assign active    = !flush && !wr_rewind;
  assign wr_ok     = wr_en && !full && active;
  assign ovf_set   = wr_en && full && active;
  assign commit_ok = wr_commit && !queue_full && active;
  assign cerr_set  = wr_commit && queue_full && active;
  assign part_inc  = part_q + CW'(wr_ok);
  assign commit_cnt = part_inc;
  assign mem_we    = wr_ok;

  always_comb begin
    wptr_d   = wptr_q;
    wstart_d = wstart_q;
    part_d   = part_q;
    if (flush) begin
      wptr_d   = '0;
      wstart_d = '0;
      part_d   = '0;
    end else if (wr_rewind) begin
      wptr_d = wstart_q;
      part_d = '0;
    end else begin
      if (wr_ok) begin
        wptr_d = (wptr_q == LAST) ? '0 : wptr_q + 1'b1;
      end
      if (commit_ok) begin
        part_d   = '0;
        wstart_d = wptr_d;
      end else begin
        part_d = part_inc;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q   <= '0;
      wstart_q <= '0;
      part_q   <= '0;
    end else begin
      wptr_q   <= wptr_d;
      wstart_q <= wstart_d;
      part_q   <= part_d;
    end
  end

  assign wptr     = wptr_q;
  assign part_cnt = part_q;

endmodule

// File: rtl/epf_read_ctrl.sv
module epf_read_ctrl #(
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH),
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          rd_en,
  input  logic          rd_release,
  input  logic          rd_rewind,
  input  logic          has_set,
  input  logic [CW-1:0] cur_count,
  output logic [AW-1:0] rptr,
  output logic          rd_ok,
  output logic          rel_ok,
  output logic          unf_set
);

  localparam int SW = AW + 1;
  localparam logic [AW-1:0] LAST    = AW'(DEPTH - 1);
  localparam logic [SW-1:0] DEPTH_S = SW'(DEPTH);

  logic [AW-1:0] rptr_q, rptr_d;
  logic [AW-1:0] rstart_q, rstart_d;
  logic [CW-1:0] roff_q, roff_d;
  logic [SW-1:0] jump_sum;
  logic [AW-1:0] jump_ptr;
  logic          byte_left;
  logic          plain_rd;

  assign byte_left = has_set && (roff_q < cur_count);
  assign plain_rd  = rd_en && !rd_rewind && !rd_release && !flush;
  assign rd_ok     = plain_rd && byte_left;
  assign unf_set   = plain_rd && !byte_left;
  assign rel_ok    = rd_release && !rd_rewind && has_set && !flush;

  // start of the following packet: wraps once at most
  assign jump_sum = {1'b0, rstart_q} + SW'(cur_count);
  assign jump_ptr = (jump_sum >= DEPTH_S) ? AW'(jump_sum - DEPTH_S) : AW'(jump_sum);

  always_comb begin
    rptr_d   = rptr_q;
    rstart_d = rstart_q;
    roff_d   = roff_q;
    if (flush) begin
      rptr_d   = '0;
      rstart_d = '0;
      roff_d   = '0;
    end else if (rd_rewind) begin
      rptr_d = rstart_q;
      roff_d = '0;
    end else if (rel_ok) begin
      rptr_d   = jump_ptr;
      rstart_d = jump_ptr;
      roff_d   = '0;
    end else if (rd_ok) begin
      rptr_d = (rptr_q == LAST) ? '0 : rptr_q + 1'b1;
      roff_d = roff_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr_q   <= '0;
      rstart_q <= '0;
      roff_q   <= '0;
    end else begin
      rptr_q   <= rptr_d;
      rstart_q <= rstart_d;
      roff_q   <= roff_d;
    end
  end

  assign rptr = rptr_q;

endmodule

// File: rtl/epf_set_queue.sv
module epf_set_queue
  import ep_dualset_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          commit_ok,
  input  logic [CW-1:0] commit_cnt,
  input  logic          rel_ok,
  output logic [CW-1:0] cnt0,
  output logic [CW-1:0] cnt1,
  output sets_e         nsets
);

  logic [CW-1:0] cnt0_q, cnt0_d;
  logic [CW-1:0] cnt1_q, cnt1_d;
  sets_e         nsets_q, nsets_d;

  always_comb begin
    cnt0_d  = cnt0_q;
    cnt1_d  = cnt1_q;
    nsets_d = nsets_q;
    if (flush) begin
      cnt0_d  = '0;
      cnt1_d  = '0;
      nsets_d = SETS_NONE;
    end else begin
      if (rel_ok) begin
        cnt0_d  = cnt1_q;
        cnt1_d  = '0;
        nsets_d = (nsets_q == SETS_TWO) ? SETS_ONE : SETS_NONE;
      end
      if (commit_ok) begin
        if (nsets_d == SETS_NONE) begin
          cnt0_d  = commit_cnt;
          nsets_d = SETS_ONE;
        end else begin
          cnt1_d  = commit_cnt;
          nsets_d = SETS_TWO;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt0_q  <= '0;
      cnt1_q  <= '0;
      nsets_q <= SETS_NONE;
    end else begin
      cnt0_q  <= cnt0_d;
      cnt1_q  <= cnt1_d;
      nsets_q <= nsets_d;
    end
  end

  assign cnt0  = cnt0_q;
  assign cnt1  = cnt1_q;
  assign nsets = nsets_q;

endmodule

// File: rtl/ep_dualset_fifo.sv
module ep_dualset_fifo
  import ep_dualset_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_commit,
  input  logic          wr_rewind,
  input  logic          rd_en,
  input  logic          rd_release,
  input  logic          rd_rewind,
  output logic [DW-1:0] rd_data,
  output logic          full,
  output logic          empty,
  output logic [CW-1:0] free_count,
  output logic [CW-1:0] cur_count,
  output logic [CW-1:0] next_count,
  output logic [1:0]    sets_held,
  output logic          overflow,
  output logic          underflow,
  output logic          commit_err,
  output logic          tx_done,
  output logic          rx_done
);

  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

  logic [AW-1:0] wptr, rptr;
  logic          mem_we;
  logic [CW-1:0] part_cnt;
  logic          commit_ok;
  logic [CW-1:0] commit_cnt;
  logic          ovf_set, cerr_set, unf_set;
  logic          rd_ok, rel_ok;
  logic [CW-1:0] cnt0, cnt1;
  sets_e         nsets;
  logic          queue_full, has_set;

  logic          ovf_q, ovf_d;
  logic          unf_q, unf_d;
  logic          cerr_q, cerr_d;
  logic          tx_q, rx_q;

  assign queue_full = (nsets == SETS_TWO);
  assign has_set    = (nsets != SETS_NONE);
  assign free_count = DEPTH_C - cnt0 - cnt1 - part_cnt;
  assign full       = (free_count == '0);
  assign empty      = !has_set;

  epf_write_ctrl #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_wr (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .wr_en      (wr_en),
    .wr_commit  (wr_commit),
    .wr_rewind  (wr_rewind),
    .full       (full),
    .queue_full (queue_full),
    .wptr       (wptr),
    .mem_we     (mem_we),
    .part_cnt   (part_cnt),
    .commit_ok  (commit_ok),
    .commit_cnt (commit_cnt),
    .ovf_set    (ovf_set),
    .cerr_set   (cerr_set)
  );

  epf_read_ctrl #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_rd (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .rd_en      (rd_en),
    .rd_release (rd_release),
    .rd_rewind  (rd_rewind),
    .has_set    (has_set),
    .cur_count  (cnt0),
    .rptr       (rptr),
    .rd_ok      (rd_ok),
    .rel_ok     (rel_ok),
    .unf_set    (unf_set)
  );

  epf_set_queue #(.DEPTH(DEPTH), .CW(CW)) u_q (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .commit_ok  (commit_ok),
    .commit_cnt (commit_cnt),
    .rel_ok     (rel_ok),
    .cnt0       (cnt0),
    .cnt1       (cnt1),
    .nsets      (nsets)
  );

  epf_store #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) u_mem (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (mem_we),
    .waddr (wptr),
    .wdata (wr_data),
    .re    (rd_ok),
    .raddr (rptr),
    .rdata (rd_data)
  );

  always_comb begin
    ovf_d  = ovf_q;
    unf_d  = unf_q;
    cerr_d = cerr_q;
    if (flush) begin
      ovf_d  = 1'b0;
      unf_d  = 1'b0;
      cerr_d = 1'b0;
    end else begin
      ovf_d  = ovf_q  | ovf_set;
      unf_d  = unf_q  | unf_set;
      cerr_d = cerr_q | cerr_set;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q  <= 1'b0;
      unf_q  <= 1'b0;
      cerr_q <= 1'b0;
      tx_q   <= 1'b0;
      rx_q   <= 1'b0;
    end else begin
      ovf_q  <= ovf_d;
      unf_q  <= unf_d;
      cerr_q <= cerr_d;
      tx_q   <= rel_ok;
      rx_q   <= commit_ok;
    end
  end

  assign cur_count  = cnt0;
  assign next_count = cnt1;
  assign sets_held  = nsets;
  assign overflow   = ovf_q;
  assign underflow  = unf_q;
  assign commit_err = cerr_q;
  assign tx_done    = tx_q;
  assign rx_done    = rx_q;

endmodule

// File: rtl/ep_dualset_fifo_chk.sv
module ep_dualset_fifo_chk #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          flush,
  input logic          wr_en,
  input logic          wr_commit,
  input logic          wr_rewind,
  input logic          rd_en,
  input logic          rd_release,
  input logic          rd_rewind,
  input logic [DW-1:0] rd_data,
  input logic          full,
  input logic          empty,
  input logic [CW-1:0] free_count,
  input logic [CW-1:0] cur_count,
  input logic [CW-1:0] next_count,
  input logic [1:0]    sets_held,
  input logic          overflow,
  input logic          underflow,
  input logic          commit_err,
  input logic          tx_done,
  input logic          rx_done
);

  AST_SETS_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    sets_held <= 2'd2); // R2

  AST_COMMIT_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit && (sets_held == 2'd2) && !wr_rewind && !flush |=> commit_err); // R2

  AST_EMPTY_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> (cur_count == '0) && (next_count == '0)); // R3

  AST_FREE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    free_count <= CW'(DEPTH)); // R11

  AST_RELEASE_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_release && !rd_rewind && !flush && !wr_commit && (sets_held == 2'd2)
    |=> (cur_count == $past(next_count)) && tx_done); // R7

  AST_COMMIT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit && (sets_held != 2'd2) && !wr_rewind && !flush |=> rx_done); // R8

  AST_FULL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    full && wr_en && !wr_rewind && !flush |=> overflow); // R9

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overflow && !flush |=> overflow); // R9

  AST_UNF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    empty && rd_en && !rd_rewind && !rd_release && !flush |=> underflow && $stable(rd_data)); // R9

  AST_FLUSH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (sets_held == 2'd0) && (free_count == CW'(DEPTH)) && !overflow && !underflow && !commit_err); // R10

endmodule

bind ep_dualset_fifo ep_dualset_fifo_chk #(.DEPTH(DEPTH), .DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .flush      (flush),
  .wr_en      (wr_en),
  .wr_commit  (wr_commit),
  .wr_rewind  (wr_rewind),
  .rd_en      (rd_en),
  .rd_release (rd_release),
  .rd_rewind  (rd_rewind),
  .rd_data    (rd_data),
  .full       (full),
  .empty      (empty),
  .free_count (free_count),
  .cur_count  (cur_count),
  .next_count (next_count),
  .sets_held  (sets_held),
  .overflow   (overflow),
  .underflow  (underflow),
  .commit_err (commit_err),
  .tx_done    (tx_done),
  .rx_done    (rx_done)
);

// File: tb/ep_dualset_fifo_tb.sv
`timescale 1ns/1ps
module ep_dualset_fifo_tb;

  localparam int D  = 16;
  localparam int DW = 8;
  localparam int CW = $clog2(D + 1);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          flush, wr_en, wr_commit, wr_rewind, rd_en, rd_release, rd_rewind;
  logic [DW-1:0] wr_data;
  logic [DW-1:0] rd_data;
  logic          full, empty, overflow, underflow, commit_err, tx_done, rx_done;
  logic [CW-1:0] free_count, cur_count, next_count;
  logic [1:0]    sets_held;

  int checks = 0;
  int errors = 0;

  // reference model state
  logic [DW-1:0] m_part[$];
  logic [DW-1:0] m_s0[$];
  logic [DW-1:0] m_s1[$];
  int            m_sets, m_roff;
  logic [DW-1:0] m_last;
  bit            m_ovf, m_unf, m_cerr, m_tx, m_rx;

  always #2.5 clk = ~clk;

  ep_dualset_fifo #(.DEPTH(D), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .wr_en(wr_en), .wr_data(wr_data),
    .wr_commit(wr_commit), .wr_rewind(wr_rewind), .rd_en(rd_en),
    .rd_release(rd_release), .rd_rewind(rd_rewind), .rd_data(rd_data),
    .full(full), .empty(empty), .free_count(free_count), .cur_count(cur_count),
    .next_count(next_count), .sets_held(sets_held), .overflow(overflow),
    .underflow(underflow), .commit_err(commit_err), .tx_done(tx_done),
    .rx_done(rx_done)
  );

  task automatic chk(string tag, string name, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, name, act, exp);
    end
  endtask

  function automatic int m_used();
    return m_part.size() + m_s0.size() + m_s1.size();
  endfunction

  function automatic void m_clear();
    m_part.delete(); m_s0.delete(); m_s1.delete();
    m_sets = 0; m_roff = 0;
    m_ovf = 0; m_unf = 0; m_cerr = 0; m_tx = 0; m_rx = 0;
  endfunction

  function automatic void m_apply(bit we, logic [DW-1:0] wd, bit com, bit wrw,
                                  bit re, bit rel, bit rrw, bit fl);
    bit was_full;
    int sets_before;
    m_tx = 0; m_rx = 0;
    if (fl) begin
      m_part.delete(); m_s0.delete(); m_s1.delete();
      m_sets = 0; m_roff = 0; m_ovf = 0; m_unf = 0; m_cerr = 0;
      return;
    end
    was_full = (m_used() == D);
    sets_before = m_sets;
    if (rrw) begin
      m_roff = 0;
    end else if (rel) begin
      if (m_sets > 0) begin
        m_s0 = m_s1; m_s1.delete(); m_sets--; m_roff = 0; m_tx = 1;
      end
    end else if (re) begin
      if (m_sets > 0 && m_roff < m_s0.size()) begin
        m_last = m_s0[m_roff]; m_roff++;
      end else begin
        m_unf = 1;
      end
    end
    if (wrw) begin
      m_part.delete();
    end else begin
      if (we) begin
        if (!was_full) m_part.push_back(wd);
        else m_ovf = 1;
      end
      if (com) begin
        if (sets_before == 2) m_cerr = 1;
        else begin
          if (m_sets == 0) m_s0 = m_part; else m_s1 = m_part;
          m_sets++; m_part.delete(); m_rx = 1;
        end
      end
    end
  endfunction

  task automatic check_all(string tag);
    chk(tag, "R1/R12 rd_data", int'(rd_data), int'(m_last));
    chk(tag, "R3 cur_count", int'(cur_count), m_s0.size());
    chk(tag, "R3 next_count", int'(next_count), m_s1.size());
    chk(tag, "R2 sets_held", int'(sets_held), m_sets);
    chk(tag, "R11 free_count", int'(free_count), D - m_used());
    chk(tag, "R4 full", int'(full), int'(m_used() == D));
    chk(tag, "R4 empty", int'(empty), int'(m_sets == 0));
    chk(tag, "R9 overflow", int'(overflow), int'(m_ovf));
    chk(tag, "R9 underflow", int'(underflow), int'(m_unf));
    chk(tag, "R2 commit_err", int'(commit_err), int'(m_cerr));
    chk(tag, "R7 tx_done", int'(tx_done), int'(m_tx));
    chk(tag, "R8 rx_done", int'(rx_done), int'(m_rx));
  endtask

  // called at a falling edge; checks at the next falling edge
  task automatic step(string tag, bit we, logic [DW-1:0] wd, bit com, bit wrw,
                      bit re, bit rel, bit rrw, bit fl);
    wr_en = we; wr_data = wd; wr_commit = com; wr_rewind = wrw;
    rd_en = re; rd_release = rel; rd_rewind = rrw; flush = fl;
    m_apply(we, wd, com, wrw, re, rel, rrw, fl);
    @(posedge clk);
    @(negedge clk);
    check_all(tag);
  endtask

  initial begin
    #(5.0 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0417));
    rst_n = 1'b0;
    flush = 0; wr_en = 0; wr_data = '0; wr_commit = 0; wr_rewind = 0;
    rd_en = 0; rd_release = 0; rd_rewind = 0;
    m_clear(); m_last = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R4 reset");

    // packet A: five writes then write+commit in one cycle (R8)
    for (int i = 0; i < 5; i++) step("R8 fill A", 1, 8'hA0 + 8'(i), 0, 0, 0, 0, 0, 0);
    step("R8 write+commit", 1, 8'hA5, 1, 0, 0, 0, 0, 0);
    // packet B
    for (int i = 0; i < 4; i++) step("R3 fill B", 1, 8'hB0 + 8'(i), 0, 0, 0, 0, 0, 0);
    step("R3 commit B", 0, '0, 1, 0, 0, 0, 0, 0);
    step("R2 third commit", 0, '0, 1, 0, 0, 0, 0, 0);
    // reads and retransmit rewind
    for (int i = 0; i < 3; i++) step("R12 read A", 0, '0, 0, 0, 1, 0, 0, 0);
    step("R5 rewind+read+release", 0, '0, 0, 0, 1, 1, 1, 0);
    for (int i = 0; i < 2; i++) step("R5 replay", 0, '0, 0, 0, 1, 0, 0, 0);
    step("R7 release A", 0, '0, 0, 0, 0, 1, 0, 0);
    // fill to full, then overflow
    for (int i = 0; i < 12; i++) step("R4 fill", 1, 8'hC0 + 8'(i), 0, 0, 0, 0, 0, 0);
    step("R9 write when full", 1, 8'hEE, 0, 0, 0, 0, 0, 0);
    step("R6 rewind+write+commit", 1, 8'hEF, 1, 1, 0, 0, 0, 0);
    // drain B then read past its end
    for (int i = 0; i < 5; i++) step("R9 drain B", 0, '0, 0, 0, 1, 0, 0, 0);
    step("R7 release last", 0, '0, 0, 0, 0, 1, 0, 0);
    step("R7 release none", 0, '0, 0, 0, 0, 1, 0, 0);
    step("R8 empty commit", 0, '0, 1, 0, 0, 0, 0, 0);
    step("R10 flush", 1, 8'h55, 1, 0, 1, 1, 0, 1);

    // random traffic with independent command bits (wraps for R1)
    for (int n = 0; n < 4000; n++) begin
      bit we, com, wrw, re, rel, rrw, fl;
      we  = ($urandom % 100) < 45;
      com = ($urandom % 100) < 9;
      wrw = ($urandom % 100) < 2;
      re  = ($urandom % 100) < 40;
      rel = ($urandom % 100) < 7;
      rrw = ($urandom % 100) < 3;
      fl  = ($urandom % 1000) < 4;
      step("R1 random", we, 8'($urandom), com, wrw, re, rel, rrw, fl);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule